// File: doc/BRIEF.md
# Programmable IR Carrier Generator

This block drives the high-current output pin of a remote-control transmitter. An output latch, set and cleared by the processor's output commands, switches transmission on and off. While it is on, the pin carries a pulse train whose period and high time come from a 3-bit carrier mode register. A dedicated command copies the processor's 4-bit pointer register into that mode register.

Six of the eight mode codes pick a fixed pair of period and duty ratio. The other two bypass the carrier, so the pin then behaves like a plain output that follows the latch. A static option bit selects the slow instruction-cycle rate, which stretches every period and high time by a factor of eight. A halt input holds the pin low while the processor sleeps. A new mode takes effect only at the next period boundary, and a rising latch always starts a fresh, full-width first pulse.

Top module: `ircg_carrier_gen`

## Requirements
- R1: While `rst_n` is low, `ir_pin` is 0 and the mode register holds code 0. After reset, a latch rise produces the mode 0 carrier (12 clocks, 4 high).
- R2: With `slow_cycle`=0, the period in clocks and the high time at the start of each period are: code 0 = 12/4, code 1 = 12/6, code 2 = 8/4, code 3 = 8/2, code 4 = 11/4, code 5 = 12/3. `ir_pin` is registered: the value for the cycle in which the latch rises appears after that clock edge.
- R3: With `slow_cycle`=1, every period and high time of R2 is multiplied by 8 (for example, code 4 becomes 88 clocks with 32 high).
- R4: A 0-to-1 change of `out_latch` restarts the carrier at phase 0, so the first pulse has full width even if the previous burst stopped in mid-period.
- R5: In the cycle after any edge at which `out_latch` is 0, `ir_pin` is 0, whatever the mode.
- R6: Codes 6 and 7 select no carrier. After each edge, `ir_pin` equals the `out_latch` value sampled at that edge.
- R7: A clock edge with `mode_load`=1 stores `mode_data[2:0]` as the pending mode. `mode_data[3]` is ignored, so 9 acts as code 1 and 15 acts as code 7.
- R8: A pending mode becomes active only at a period boundary (phase 0). Such a boundary is a period wrap, a latch rise, any cycle with the latch low, or any cycle while a no-carrier code is active. The period in progress finishes in the old mode.
- R9: After any edge at which `halt` is 1, `ir_pin` is 0. When `halt` drops while `out_latch` stays 1, the carrier restarts at phase 0 as for a latch rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_cycle | input | 1 | Slow instruction-cycle option; scales all timing by 8 |
| halt | input | 1 | Processor sleep; forces the pin low |
| mode_load | input | 1 | Mode register load strobe |
| mode_data | input | 4 | Register value copied into the mode register (low 3 bits used) |
| out_latch | input | 1 | Output latch level that gates transmission |
| ir_pin | output | 1 | Output pin level, active high |

## Verification
The bench goes after the mode switch in mid-period: a design that applies a new code at once would emit a cut-short pulse, or a period of mixed length, before the boundary. It stops a burst in mid-period and restarts it, which exposes a counter that resumes where it stopped and so gives a narrow first pulse. It checks the 4/11 code in both rate options, where a wrong scale factor or a wrong high count shows up as a shifted falling edge. It also checks that bit 3 of the load value is dropped, and that release from halt restarts the phase; a design that got these wrong would pick the wrong mode or resume with a partial pulse.

// File: rtl/ircg_pkg.sv
package ircg_pkg;

    localparam int MODE_W = 3;
    localparam int DATA_W = 4;
    localparam int BASE_W = 4;

    typedef logic [MODE_W-1:0] mode_t;

    typedef struct packed {
        logic [BASE_W-1:0] per;
        logic [BASE_W-1:0] hi;
        logic              bypass;
    } shape_t;

    // Base (fast option) carrier shapes; codes 6 and 7 have no carrier.
    function automatic shape_t mode_shape(input mode_t m);
        shape_t s;
        s.bypass = 1'b0;
        case (m)
            3'd0:    begin s.per = 4'd12; s.hi = 4'd4; end
            3'd1:    begin s.per = 4'd12; s.hi = 4'd6; end
            3'd2:    begin s.per = 4'd8;  s.hi = 4'd4; end
            3'd3:    begin s.per = 4'd8;  s.hi = 4'd2; end
            3'd4:    begin s.per = 4'd11; s.hi = 4'd4; end
            3'd5:    begin s.per = 4'd12; s.hi = 4'd3; end
            default: begin s.per = 4'd1;  s.hi = 4'd0; s.bypass = 1'b1; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ircg_timing.sv
module ircg_timing
    import ircg_pkg::*;
#(
    parameter int SLOW_MULT = 8,
    parameter int CNT_W     = 7
) (
    input  mode_t            mode,
    input  logic             slow,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] high,
    output logic             bypass
);
    shape_t shp;
    logic [CNT_W-1:0] base_per;
    logic [CNT_W-1:0] base_hi;

    always_comb begin
        shp      = mode_shape(mode);
        base_per = CNT_W'(shp.per);
        base_hi  = CNT_W'(shp.hi);
        bypass   = shp.bypass;
    end

    generate
        if ((SLOW_MULT & (SLOW_MULT - 1)) == 0) begin : g_shift
            localparam int SH = $clog2(SLOW_MULT);
            always_comb begin
                period = slow ? (base_per << SH) : base_per;
                high   = slow ? (base_hi  << SH) : base_hi;
            end
        end else begin : g_mult
            always_comb begin
                period = slow ? CNT_W'(base_per * SLOW_MULT) : base_per;
                high   = slow ? CNT_W'(base_hi  * SLOW_MULT) : base_hi;
            end
        end
    endgenerate

endmodule

// File: rtl/ircg_mode_hold.sv
module ircg_mode_hold
    import ircg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output mode_t             pend
);
    mode_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (load) pend_d = data[MODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    assert_load_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pend_q == $past(data[MODE_W-1:0])));

endmodule

// File: rtl/ircg_carrier_gen.sv
module ircg_carrier_gen
    import ircg_pkg::*;
#(
    parameter int SLOW_MULT = 8,
    parameter int MAX_BASE  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_cycle,
    input  logic              halt,
    input  logic              mode_load,
    input  logic [DATA_W-1:0] mode_data,
    input  logic              out_latch,
    output logic              ir_pin
);
    localparam int CNT_W = $clog2(MAX_BASE * SLOW_MULT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        mode_t            mode;
        logic             latch;
        logic             pin;
    } state_t;

    state_t st_d, st_q;
    mode_t  pend_mode;

    logic [CNT_W-1:0] cur_per, cur_hi, nxt_per, nxt_hi;
    logic             cur_byp, nxt_byp;

    ircg_mode_hold i_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .data  (mode_data),
        .pend  (pend_mode)
    );

    ircg_timing #(.SLOW_MULT(SLOW_MULT), .CNT_W(CNT_W)) i_cur_tim (
        .mode   (st_q.mode),
        .slow   (slow_cycle),
        .period (cur_per),
        .high   (cur_hi),
        .bypass (cur_byp)
    );

    ircg_timing #(.SLOW_MULT(SLOW_MULT), .CNT_W(CNT_W)) i_nxt_tim (
        .mode   (pend_mode),
        .slow   (slow_cycle),
        .period (nxt_per),
        .high   (nxt_hi),
        .bypass (nxt_byp)
    );

    logic             rise;
    logic             at_bound;
    logic [CNT_W-1:0] ph;
    logic [CNT_W-1:0] use_per, use_hi;
    logic             use_byp;
    mode_t            use_mode;

    always_comb begin
        st_d     = st_q;
        rise     = out_latch & ~st_q.latch;
        ph       = rise ? '0 : st_q.cnt;
        at_bound = (ph == '0) | cur_byp;
        use_mode = at_bound ? pend_mode : st_q.mode;
        use_per  = at_bound ? nxt_per   : cur_per;
        use_hi   = at_bound ? nxt_hi    : cur_hi;
        use_byp  = at_bound ? nxt_byp   : cur_byp;

        if (halt) begin
            st_d.pin   = 1'b0;
            st_d.cnt   = '0;
            st_d.latch = 1'b0;
        end else begin
            st_d.latch = out_latch;
            st_d.mode  = use_mode;
            st_d.pin   = out_latch & (use_byp | (ph < use_hi));
            if (!out_latch || use_byp)
                st_d.cnt = '0;
            else if (ph == use_per - CNT_W'(1))
                st_d.cnt = '0;
            else
                st_d.cnt = ph + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ir_pin = st_q.pin;

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |-> !ir_pin);

    assert_halt_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !ir_pin);

    assert_latch_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_latch |=> !ir_pin);

    assert_first_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_latch && !st_q.latch && !halt) |=> ir_pin);

    assert_phase_in_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_byp |-> (st_q.cnt < cur_per));

endmodule

// File: tb/test_ircg_carrier_gen.sv
module test_ircg_carrier_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_cycle = 1'b0;
    logic       halt = 1'b0;
    logic       mode_load = 1'b0;
    logic [3:0] mode_data = 4'd0;
    logic       out_latch = 1'b0;
    logic       ir_pin;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    ircg_carrier_gen i_ircg_carrier_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_cycle (slow_cycle),
        .halt       (halt),
        .mode_load  (mode_load),
        .mode_data  (mode_data),
        .out_latch  (out_latch),
        .ir_pin     (ir_pin)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic exp, input string tag, input int k);
        vectors++;
        if (ir_pin !== exp) begin
            misses++;
            $display("FAIL %s step %0d: ir_pin=%b expected %b", tag, k, ir_pin, exp);
        end
    endtask

    task automatic setup(input logic [3:0] code, input logic slow);
        out_latch  = 1'b0;
        halt       = 1'b0;
        slow_cycle = slow;
        mode_load  = 1'b1;
        mode_data  = code;
        tick();
        mode_load  = 1'b0;
        tick();
    endtask

    task automatic run(input int per, input int hi, input int n, input string tag);
        out_latch = 1'b1;
        for (int k = 0; k < n; k++) begin
            tick();
            chk((k % per) < hi, tag, k);
        end
    endtask

    // R1: reset state and default mode 0
    task automatic t_reset();
        rst_n = 1'b0;
        out_latch = 1'b1;
        tick();
        chk(1'b0, "R1 reset", 0);
        out_latch = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chk(1'b0, "R1 after reset", 1);
        run(12, 4, 24, "R1 default mode");
    endtask

    // R2: every carrier code with the fast option
    task automatic t_modes();
        int per [6] = '{12, 12, 8, 8, 11, 12};
        int hi  [6] = '{4, 6, 4, 2, 4, 3};
        for (int m = 0; m < 6; m++) begin
            setup(4'(m), 1'b0);
            run(per[m], hi[m], 3 * per[m], "R2 fast mode");
        end
    endtask

    // R3: slow option scales by 8
    task automatic t_slow();
        setup(4'd4, 1'b1);
        run(88, 32, 180, "R3 slow 4/11");
        setup(4'd3, 1'b1);
        run(64, 16, 130, "R3 slow 1/4");
        setup(4'd0, 1'b0);
    endtask

    // R4 and R5: stop in mid-period, then restart with a full first pulse
    task automatic t_restart();
        setup(4'd1, 1'b0);
        run(12, 6, 8, "R4 first burst");
        out_latch = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(1'b0, "R5 latch low", k);
        end
        run(12, 6, 24, "R4 restart");
    endtask

    // R5: latch low keeps the pin low for every code
    task automatic t_low();
        for (int m = 0; m < 8; m++) begin
            setup(4'(m), 1'b0);
            for (int k = 0; k < 4; k++) begin
                tick();
                chk(1'b0, "R5 idle", k);
            end
        end
    endtask

    // R6: codes 6 and 7 pass the latch through
    task automatic t_bypass();
        logic [15:0] pat = 16'b1011_0011_1000_1101;
        for (int m = 6; m < 8; m++) begin
            setup(4'(m), 1'b0);
            for (int k = 0; k < 16; k++) begin
                out_latch = pat[k];
                tick();
                chk(pat[k], "R6 bypass", k);
            end
        end
        out_latch = 1'b0;
    endtask

    // R7: bit 3 of the load value is ignored
    task automatic t_bit3();
        setup(4'd9, 1'b0);
        run(12, 6, 24, "R7 code 9 as 1");
        setup(4'd15, 1'b0);
        out_latch = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tick();
            chk(1'b1, "R7 code 15 as 7", k);
        end
        out_latch = 1'b0;
        tick();
        chk(1'b0, "R7 code 15 as 7 off", 6);
    endtask

    // R8: a new code waits for the period boundary
    task automatic t_switch();
        logic e;
        setup(4'd0, 1'b0);
        out_latch = 1'b1;
        for (int k = 0; k < 40; k++) begin
            mode_load = (k == 5);
            mode_data = 4'd2;
            tick();
            e = (k < 12) ? ((k % 12) < 4) : (((k - 12) % 8) < 4);
            chk(e, "R8 switch 0->2", k);
        end
        mode_load = 1'b0;
    endtask

    // R9: halt forces low, release restarts the phase
    task automatic t_halt();
        setup(4'd2, 1'b0);
        run(8, 4, 6, "R9 before halt");
        halt = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(1'b0, "R9 halted", k);
        end
        halt = 1'b0;
        run(8, 4, 16, "R9 after halt");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_modes();
        t_slow();
        t_restart();
        t_low();
        t_bypass();
        t_bit3();
        t_switch();
        t_halt();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule